// File: doc/BRIEF.md
# Scaled Integer-to-Float Converter

This block turns a 32-bit integer into an IEEE-754 single-precision value and divides the result by a power of two between 2^0 and 2^-15. The divisor comes from a 4-bit scale field. One operation therefore converts a fixed-point number with up to 15 fraction bits into a float. A select input says whether the integer is two's-complement signed or plain unsigned. A 2-bit rounding-mode input chooses how the 32-bit magnitude is cut down to 24 significant bits.

The unit accepts one operand per cycle on a valid strobe. It returns the packed float and an inexact flag one clock later, with an output valid pulse. Between results the outputs hold their last value. Rounding happens once, on the unscaled magnitude. The scale can lower the exponent by at most 15, so the scaled result is always a normal number and the scaling step adds no error.

Top module: `fxf_convert`

## Requirements
- R1: A result appears on the outputs in the cycle after `in_valid` is sampled high, with `out_valid` high for exactly that one cycle. While reset is asserted, `out_valid`, `out_float` and `out_inexact` are all 0.
- R2: When `in_unsigned` is 0, `in_int` is read as two's complement. For example, 0x80000000 at scale 0 gives exactly -2^31 (0xCF000000), and 0xFFFFFFFF gives -1.0 (0xBF800000).
- R3: When `in_unsigned` is 1, `in_int` is read as unsigned and the sign bit of the result is always 0. For example, 0xFFFFFFFF rounded to nearest gives 2^32 (0x4F800000) with inexact set.
- R4: The converted value is multiplied by 2^-t, where t is `in_scale` (0 to 15). This lowers the 8-bit exponent field (bits 30:23) by t and leaves the 23-bit fraction field (bits 22:0) unchanged. For example, 1 at scale 15 gives 0x38000000.
- R5: `in_rmode` = 0 rounds to nearest. An exact tie goes to the value whose least significant kept bit is 0. A carry out of the 24-bit significand raises the exponent by one.
- R6: `in_rmode` = 1 rounds toward zero, which truncates the magnitude.
- R7: `in_rmode` = 2 rounds toward minus infinity. The magnitude grows for inexact negative values and is truncated for positive values.
- R8: `in_rmode` = 3 rounds toward plus infinity. The magnitude grows for inexact positive values and is truncated for negative values.
- R9: An input of 0 gives +0.0 (0x00000000) with inexact clear, for any scale, mode and select.
- R10: `out_inexact` is 1 exactly when nonzero bits are dropped while fitting the magnitude into 24 significant bits. Any magnitude below 2^24 converts exactly.
- R11: When `in_valid` is low, `out_float` and `out_inexact` keep their previous values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operand strobe |
| in_int | input | 32 | Integer operand |
| in_scale | input | 4 | Power-of-two divisor exponent t |
| in_unsigned | input | 1 | 1 = unsigned operand, 0 = signed operand |
| in_rmode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 toward minus infinity, 3 toward plus infinity |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_float | output | 32 | Single-precision result |
| out_inexact | output | 1 | Dropped nonzero bits during rounding |

## Verification
There is one register stage, so a wrong leading-zero count or a wrong rounding decision shows at the ports in the very next cycle. It appears as a shifted fraction, an exponent off by the count error, or a result off by one unit in the last place. The same cycle also shows a misplaced significand carry, as a fraction that is not zero next to an exponent that was bumped. The hold behaviour is checked by changing the inputs while the strobe is low and then comparing the outputs with the previous result.

// File: rtl/fxf_pkg.sv
package fxf_pkg;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'd0,
    RM_ZERO    = 2'd1,
    RM_DOWN    = 2'd2,
    RM_UP      = 2'd3
  } rmode_e;

  // Decide whether the kept significand gets one added in its last place.
  function automatic logic round_incr(input rmode_e rm, input logic neg,
                                      input logic lsb, input logic guard,
                                      input logic sticky);
    logic lost;
    lost = guard | sticky;
    unique case (rm)
      RM_NEAREST: round_incr = guard & (sticky | lsb);
      RM_ZERO:    round_incr = 1'b0;
      RM_DOWN:    round_incr = neg & lost;
      RM_UP:      round_incr = ~neg & lost;
      default:    round_incr = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fxf_magnitude.sv
module fxf_magnitude #(
  parameter int INT_W = 32
) (
  input  logic [INT_W-1:0] value,
  input  logic             is_unsigned,
  output logic             neg,
  output logic [INT_W-1:0] mag
);
  always_comb begin
    neg = ~is_unsigned & value[INT_W-1];
    mag = neg ? (~value + INT_W'(1)) : value;
  end
endmodule

// File: rtl/fxf_normalize.sv
module fxf_normalize #(
  parameter int INT_W = 32,
  localparam int LZ_W = $clog2(INT_W)
) (
  input  logic [INT_W-1:0] mag,
  output logic [LZ_W-1:0]  lz,
  output logic [INT_W-1:0] norm,
  output logic             zero
);
  always_comb begin
    lz = '0;
    for (int i = 0; i < INT_W; i++) begin
      if (mag[i]) lz = LZ_W'(INT_W - 1 - i);
    end
    zero = (mag == '0);
    norm = mag << lz;
  end
endmodule

// File: rtl/fxf_round_pack.sv
module fxf_round_pack #(
  parameter int INT_W   = 32,
  parameter int SCALE_W = 4,
  localparam int LZ_W   = $clog2(INT_W),
  localparam int SIG_W  = 24,
  localparam int DROP_W = INT_W - SIG_W,
  localparam int BIAS   = 127
) (
  input  logic               neg,
  input  logic               zero,
  input  logic [INT_W-1:0]   norm,
  input  logic [LZ_W-1:0]    lz,
  input  logic [SCALE_W-1:0] scale,
  input  fxf_pkg::rmode_e    rm,
  output logic [31:0]        fp,
  output logic               inexact,
  output logic               carry
);
  localparam logic [7:0] EXP_TOP = 8'(BIAS + INT_W - 1);

  logic [SIG_W-1:0] sig;
  logic             guard, sticky, incr;
  logic [SIG_W:0]   sum;
  logic [7:0]       expo;
  logic [22:0]      frac;

  always_comb begin
    sig     = norm[INT_W-1 -: SIG_W];
    guard   = norm[DROP_W-1];
    sticky  = |norm[DROP_W-2:0];
    incr    = fxf_pkg::round_incr(rm, neg, sig[0], guard, sticky);
    sum     = {1'b0, sig} + {{SIG_W{1'b0}}, incr};
    carry   = sum[SIG_W];
    frac    = carry ? sum[SIG_W-1:1] : sum[SIG_W-2:0];
    expo    = EXP_TOP - 8'(lz) - 8'(scale) + 8'(carry);
    inexact = ~zero & (guard | sticky);
    fp      = zero ? 32'd0 : {neg, expo, frac};
  end
endmodule

// File: rtl/fxf_convert.sv
module fxf_convert #(
  parameter int INT_W   = 32,
  parameter int SCALE_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [INT_W-1:0]   in_int,
  input  logic [SCALE_W-1:0] in_scale,
  input  logic               in_unsigned,
  input  logic [1:0]         in_rmode,
  output logic               out_valid,
  output logic [31:0]        out_float,
  output logic               out_inexact
);
  localparam int LZ_W = $clog2(INT_W);

  logic             neg_w, zero_w, carry_w, inexact_w;
  logic [INT_W-1:0] mag_w, norm_w;
  logic [LZ_W-1:0]  lz_w;
  logic [31:0]      fp_w;

  fxf_magnitude #(.INT_W(INT_W)) u_mag (
    .value(in_int), .is_unsigned(in_unsigned), .neg(neg_w), .mag(mag_w)
  );

  fxf_normalize #(.INT_W(INT_W)) u_norm (
    .mag(mag_w), .lz(lz_w), .norm(norm_w), .zero(zero_w)
  );

  fxf_round_pack #(.INT_W(INT_W), .SCALE_W(SCALE_W)) u_rnd (
    .neg(neg_w), .zero(zero_w), .norm(norm_w), .lz(lz_w), .scale(in_scale),
    .rm(fxf_pkg::rmode_e'(in_rmode)), .fp(fp_w), .inexact(inexact_w),
    .carry(carry_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_float   <= '0;
      out_inexact <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_float   <= fp_w;
        out_inexact <= inexact_w;
      end
    end
  end
endmodule

// File: rtl/fxf_convert_chk.sv
module fxf_convert_chk #(
  parameter int INT_W   = 32,
  parameter int SCALE_W = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [INT_W-1:0]   in_int,
  input logic [SCALE_W-1:0] in_scale,
  input logic               in_unsigned,
  input logic [1:0]         in_rmode,
  input logic               out_valid,
  input logic [31:0]        out_float,
  input logic               out_inexact,
  input logic               carry_w
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_signed_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_unsigned && in_int[INT_W-1]) |=> out_float[31]);
  assert_unsigned_positive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_unsigned) |=> !out_float[31]);
  assert_exp_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_float != 32'd0) |->
      (out_float[30:23] >= 8'd112 && out_float[30:23] <= 8'd159));
  assert_carry_frac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && carry_w) |=> out_float[22:0] == 23'd0);
  assert_trunc_no_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_rmode == 2'd1) |-> !carry_w);
  assert_zero_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_int == '0) |=> (out_float == 32'd0 && !out_inexact));
  assert_small_exact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_unsigned && in_int < (INT_W'(1) << 24)) |=> !out_inexact);
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_float) && $stable(out_inexact)));
  // Scale and mode inputs are only meaningful with the strobe; kept for binding.
  logic unused_ok;
  assign unused_ok = ^in_scale;
endmodule

bind fxf_convert fxf_convert_chk #(.INT_W(INT_W), .SCALE_W(SCALE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
  .in_scale(in_scale), .in_unsigned(in_unsigned), .in_rmode(in_rmode),
  .out_valid(out_valid), .out_float(out_float), .out_inexact(out_inexact),
  .carry_w(carry_w)
);

// File: tb/test_fxf_convert.sv
`timescale 1ns/1ps
module test_fxf_convert;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_int = '0;
  logic [3:0]  in_scale = '0;
  logic        in_unsigned = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        out_valid;
  logic [31:0] out_float;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fxf_convert i_fxf_convert (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_int(in_int),
    .in_scale(in_scale), .in_unsigned(in_unsigned), .in_rmode(in_rmode),
    .out_valid(out_valid), .out_float(out_float), .out_inexact(out_inexact)
  );

  // Reference model: {inexact, float}, built by remainder comparison.
  function automatic logic [32:0] model(input logic [31:0] v, input logic [3:0] t,
                                        input logic u, input logic [1:0] rm);
    logic s, up, inx;
    logic [63:0] m, kept, rem, half;
    int p, drop;
    logic [7:0] e;
    s = !u && v[31];
    m = s ? (64'h1_0000_0000 - {32'd0, v}) : {32'd0, v};
    if (m == 64'd0) return 33'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (m[i]) p = i;
    up = 1'b0; inx = 1'b0;
    if (p <= 23) kept = m << (23 - p);
    else begin
      drop = p - 23;
      kept = m >> drop;
      rem  = m - (kept << drop);
      half = 64'd1 << (drop - 1);
      inx  = (rem != 64'd0);
      case (rm)
        2'd0: up = (rem > half) || (rem == half && kept[0]);
        2'd1: up = 1'b0;
        2'd2: up = s && inx;
        default: up = !s && inx;
      endcase
    end
    kept = kept + {63'd0, up};
    if (kept[24]) begin kept = kept >> 1; p = p + 1; end
    e = 8'(127 + p - int'(t));
    return {inx, s, e, kept[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic run_op(input string tag, input logic [31:0] v, input logic [3:0] t,
                        input logic u, input logic [1:0] rm);
    logic [32:0] exp_r;
    exp_r = model(v, t, u, rm);
    in_int = v; in_scale = t; in_unsigned = u; in_rmode = rm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " R1 valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " float"}, out_float, exp_r[31:0]);
    check({tag, " R10 inexact"}, {31'd0, out_inexact}, {31'd0, exp_r[32]});
  endtask

  task automatic idle_hold(input logic [31:0] prev_f, input logic prev_x);
    in_int = $urandom; in_scale = 4'($urandom); in_unsigned = 1'($urandom);
    in_rmode = 2'($urandom);
    @(negedge clk);
    check("R1 valid low", {31'd0, out_valid}, 32'd0);
    check("R11 hold float", out_float, prev_f);
    check("R11 hold inexact", {31'd0, out_inexact}, {31'd0, prev_x});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240917));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset float", out_float, 32'd0);
    check("R1 reset inexact", {31'd0, out_inexact}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    run_op("R2 min int", 32'h8000_0000, 4'd0, 1'b0, 2'd0);
    check("R2 min int const", out_float, 32'hCF00_0000);
    run_op("R2 minus one", 32'hFFFF_FFFF, 4'd0, 1'b0, 2'd0);
    check("R2 minus one const", out_float, 32'hBF80_0000);
    run_op("R3 max unsigned", 32'hFFFF_FFFF, 4'd0, 1'b1, 2'd0);
    check("R3 max unsigned const", out_float, 32'h4F80_0000);
    run_op("R4 one scaled", 32'd1, 4'd15, 1'b0, 2'd0);
    check("R4 one scaled const", out_float, 32'h3800_0000);
    run_op("R4 min int scaled", 32'h8000_0000, 4'd15, 1'b0, 2'd3);
    run_op("R5 tie even", 32'h0100_0001, 4'd0, 1'b1, 2'd0);
    run_op("R5 tie odd", 32'h0100_0003, 4'd0, 1'b1, 2'd0);
    run_op("R5 carry", 32'h01FF_FFFF, 4'd3, 1'b1, 2'd0);
    check("R5 carry const", out_float, 32'h4A80_0000);
    for (int rm = 0; rm < 4; rm++) begin
      run_op("R6 R7 R8 negative", 32'hFEFF_FFFF, 4'd2, 1'b0, 2'(rm));
      run_op("R6 R7 R8 positive", 32'h0100_0001, 4'd2, 1'b0, 2'(rm));
    end
    run_op("R7 down carry", 32'hFE00_0001, 4'd0, 1'b0, 2'd2);
    run_op("R8 up carry", 32'h01FF_FFFF, 4'd0, 1'b0, 2'd3);
    run_op("R9 zero signed", 32'd0, 4'd7, 1'b0, 2'd2);
    check("R9 zero const", out_float, 32'd0);
    run_op("R9 zero unsigned", 32'd0, 4'd15, 1'b1, 2'd3);
    run_op("R10 exact 24 bit", 32'h00FF_FFFF, 4'd9, 1'b1, 2'd3);
    idle_hold(out_float, out_inexact);

    for (int n = 0; n < 3000; n++) begin
      logic [31:0] v;
      v = $urandom;
      case ($urandom % 4)
        0: v = v >> ($urandom % 32);
        1: v = v | 32'h8000_0000;
        default: ;
      endcase
      run_op("R2 R3 R4 random", v, 4'($urandom), 1'($urandom), 2'($urandom));
      if (n % 50 == 0) idle_hold(out_float, out_inexact);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule